// File: doc/BRIEF.md
# Rate-Limited Line Violation Monitor

This block watches a stream of single-cycle violation pulses coming from a line-code decoder and turns them into three toggling status bits. Software reads the bits at its own pace and estimates the error rate from how often each one has changed. One bit, the main bit, changes once per 256 accepted violations, and it is held so that it never changes more often than once per 96 ms. The 96 ms window is measured in ticks of a 1 ms timebase input. Two auxiliary bits change once per 128 and once per 64 violations, with no rate limit.

When the main divider has reached 256 before the window has closed, it waits for the window to close. Any violation seen while it waits is discarded. Once the window has closed, the 256th violation toggles the main bit at once. On each main toggle, both the main count and the window count start again from zero. The auxiliary bits run from a free counter that does not depend on the hold state of the main divider.

Top module: `bpv_rate_monitor`

## Requirements
- R1: During reset and on the first cycle after it, bpv_main, bpv_aux_hi and bpv_aux_lo are all 0.
- R2: When the 96-tick window has already closed, bpv_main inverts on the clock edge that samples the 256th accepted violation.
- R3: bpv_main never changes before 96 ms_tick pulses have been sampled since reset release or since its previous change.
- R4: When 256 violations are already held, bpv_main inverts on the clock edge that samples the 96th ms_tick of the window.
- R5: A violation sampled while 256 are held, including one sampled on the edge where the main bit inverts, is discarded and does not count toward the next 256.
- R6: On the edge where bpv_main inverts, the accepted count and the tick count both restart at zero, and an ms_tick sampled on that edge does not count.
- R7: bpv_aux_lo inverts on the edge that samples every 64th violation since reset, whatever the hold state of the main divider.
- R8: bpv_aux_hi inverts on the edge that samples every 128th violation since reset, on the same edge as bpv_aux_lo.
- R9: Without a sampled violation, bpv_aux_lo and bpv_aux_hi keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_pulse | input | 1 | One violation per cycle in which it is high |
| ms_tick | input | 1 | One-cycle pulse per millisecond of timebase |
| bpv_main | output | 1 | Toggles per 256 accepted violations, rate limited |
| bpv_aux_hi | output | 1 | Toggles per 128 violations |
| bpv_aux_lo | output | 1 | Toggles per 64 violations |

## Verification
The bench targets two cases where events fall on the same clock edge. In the first, the closing tick of the window and the 256th violation arrive on one edge. In the second, a held violation arrives on the edge where the main bit is released. Directed sequences set these up by counting out 255 violations and 95 ticks and then driving the final pulses together. Random traffic with frequent ticks produces further overlaps, including auxiliary and main toggles on the same edge. The bench judges each edge against a reference model built from the requirements: the release must take the 256th violation or the 96th tick on that edge, and it must drop both a held violation and the tick on that edge.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

   // True when v is a positive power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Width needed to hold values 0..v inclusive.
   function automatic int unsigned span_width(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/bpv_hold_timer.sv
module bpv_hold_timer
   import bpv_pkg::*;
#(
   parameter int unsigned HOLD_TICKS = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic window_done
);
   localparam int unsigned HCW = span_width(HOLD_TICKS);
   localparam logic [HCW-1:0] HOLD_MAX  = HCW'(HOLD_TICKS);
   localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_TICKS - 1);

   logic [HCW-1:0] tick_cnt;

   generate
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("HOLD_TICKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (restart) begin
         tick_cnt <= '0;
      end else if (tick && (tick_cnt != HOLD_MAX)) begin
         tick_cnt <= tick_cnt + 1'b1;
      end
   end

   // The window closes on the edge that samples the last required tick.
   always_comb begin
      window_done = (tick_cnt == HOLD_MAX) || (tick && (tick_cnt == HOLD_LAST));
   end

   assert_tick_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cnt <= HOLD_MAX);

   assert_restart_needs_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> window_done);

   assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (tick_cnt == '0));

endmodule

// File: rtl/bpv_main_div.sv
module bpv_main_div
   import bpv_pkg::*;
#(
   parameter int unsigned MAIN_DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic viol,
   input  logic release_ok,
   output logic fire,
   output logic main_bit
);
   localparam int unsigned MCW = span_width(MAIN_DIV);
   localparam logic [MCW-1:0] CNT_FULL = MCW'(MAIN_DIV);
   localparam logic [MCW-1:0] CNT_LAST = MCW'(MAIN_DIV - 1);

   logic [MCW-1:0] acc_cnt;
   logic           held_full;
   logic           reach;

   generate
      if (MAIN_DIV < 2) begin : g_bad_main
         $error("MAIN_DIV must be at least 2");
      end
   endgenerate

   always_comb begin
      held_full = (acc_cnt == CNT_FULL);
      reach     = held_full || (viol && (acc_cnt == CNT_LAST));
      fire      = reach && release_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt  <= '0;
         main_bit <= 1'b0;
      end else if (fire) begin
         acc_cnt  <= '0;
         main_bit <= ~main_bit;
      end else if (viol && !held_full) begin
         acc_cnt  <= acc_cnt + 1'b1;
      end
   end

   assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cnt <= CNT_FULL);

   assert_held_discards_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (held_full && !release_ok) |=> (acc_cnt == CNT_FULL));

   assert_fire_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (acc_cnt == '0));

endmodule

// File: rtl/bpv_aux_div.sv
module bpv_aux_div
   import bpv_pkg::*;
#(
   parameter int unsigned AUX_HI_DIV = 128,
   parameter int unsigned AUX_LO_DIV = 64,
   parameter bit          SHARED_CNT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic viol,
   output logic aux_hi,
   output logic aux_lo
);
   localparam int unsigned HW = $clog2(AUX_HI_DIV);
   localparam int unsigned LW = $clog2(AUX_LO_DIV);

   logic hi_wrap;
   logic lo_wrap;

   generate
      if (!is_pow2(AUX_HI_DIV) || !is_pow2(AUX_LO_DIV) || AUX_LO_DIV < 2
          || AUX_LO_DIV > AUX_HI_DIV) begin : g_bad_aux
         $error("aux dividers must be powers of two with 2 <= LO <= HI");
      end

      if (SHARED_CNT) begin : g_shared
         // One free counter; the low divider watches its low bits.
         logic [HW-1:0] free_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               free_cnt <= '0;
            end else if (viol) begin
               free_cnt <= free_cnt + 1'b1;
            end
         end
         always_comb begin
            hi_wrap = viol && (&free_cnt);
            lo_wrap = viol && (&free_cnt[LW-1:0]);
         end
      end else begin : g_split
         // Two independent free counters.
         logic [HW-1:0] hi_cnt;
         logic [LW-1:0] lo_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_cnt <= '0;
               lo_cnt <= '0;
            end else if (viol) begin
               hi_cnt <= hi_cnt + 1'b1;
               lo_cnt <= lo_cnt + 1'b1;
            end
         end
         always_comb begin
            hi_wrap = viol && (&hi_cnt);
            lo_wrap = viol && (&lo_cnt);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_hi <= 1'b0;
         aux_lo <= 1'b0;
      end else begin
         if (hi_wrap) aux_hi <= ~aux_hi;
         if (lo_wrap) aux_lo <= ~aux_lo;
      end
   end

   assert_aux_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !viol |=> ($stable(aux_hi) && $stable(aux_lo)));

   assert_hi_with_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_hi != $past(aux_hi)) |-> (aux_lo != $past(aux_lo)));

endmodule

// File: rtl/bpv_rate_monitor.sv
module bpv_rate_monitor
   import bpv_pkg::*;
#(
   parameter int unsigned MAIN_DIV   = 256,
   parameter int unsigned HOLD_TICKS = 96,
   parameter int unsigned AUX_HI_DIV = 128,
   parameter int unsigned AUX_LO_DIV = 64,
   parameter bit          SHARED_CNT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic viol_pulse,
   input  logic ms_tick,
   output logic bpv_main,
   output logic bpv_aux_hi,
   output logic bpv_aux_lo
);
   logic window_done;
   logic main_fire;

   bpv_hold_timer #(
      .HOLD_TICKS (HOLD_TICKS)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (ms_tick),
      .restart     (main_fire),
      .window_done (window_done)
   );

   bpv_main_div #(
      .MAIN_DIV (MAIN_DIV)
   ) u_main (
      .clk        (clk),
      .rst_n      (rst_n),
      .viol       (viol_pulse),
      .release_ok (window_done),
      .fire       (main_fire),
      .main_bit   (bpv_main)
   );

   bpv_aux_div #(
      .AUX_HI_DIV (AUX_HI_DIV),
      .AUX_LO_DIV (AUX_LO_DIV),
      .SHARED_CNT (SHARED_CNT)
   ) u_aux (
      .clk    (clk),
      .rst_n  (rst_n),
      .viol   (viol_pulse),
      .aux_hi (bpv_aux_hi),
      .aux_lo (bpv_aux_lo)
   );

   assert_main_only_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bpv_main != $past(bpv_main)) |-> $past(window_done));

   assert_main_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bpv_main != $past(bpv_main)) |-> ($past(viol_pulse) || $past(ms_tick)));

endmodule

// File: tb/bpv_rate_monitor_tb.sv
module bpv_rate_monitor_tb;
   localparam int MAIN_N = 256;
   localparam int HOLD_N = 96;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic viol_pulse = 1'b0;
   logic ms_tick = 1'b0;
   logic bpv_main, bpv_aux_hi, bpv_aux_lo;

   int checks = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   // reference model state
   int m_cnt = 0;
   int m_hold = 0;
   int a_cnt = 0;
   bit m_main = 1'b0;
   bit m_hi = 1'b0;
   bit m_lo = 1'b0;

   always #4 clk = ~clk;

   bpv_rate_monitor u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .viol_pulse (viol_pulse),
      .ms_tick    (ms_tick),
      .bpv_main   (bpv_main),
      .bpv_aux_hi (bpv_aux_hi),
      .bpv_aux_lo (bpv_aux_lo)
   );

   function automatic bit release_now(int cnt, int hold, bit v, bit t);
      bit reach = (cnt == MAIN_N) || (v && cnt == MAIN_N - 1);
      bit win   = (hold == HOLD_N) || (t && hold == HOLD_N - 1);
      return reach && win;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_step(bit v, bit t);
      if (release_now(m_cnt, m_hold, v, t)) begin
         m_main = ~m_main;
         m_cnt  = 0;
         m_hold = 0;
      end else begin
         if (v && m_cnt < MAIN_N) m_cnt++;
         if (t && m_hold < HOLD_N) m_hold++;
      end
      if (v) begin
         a_cnt++;
         if (a_cnt % 64 == 0) m_lo = ~m_lo;
         if (a_cnt % 128 == 0) m_hi = ~m_hi;
      end
   endtask

   // Drive inputs 2 ns after an edge, step the model at the edge, compare 2 ns later.
   task automatic cyc(bit v, bit t);
      viol_pulse = v;
      ms_tick    = t;
      @(posedge clk);
      model_step(v, t);
      #2;
      chk("R4", "bpv_main", bpv_main, m_main);
      chk("R7", "bpv_aux_lo", bpv_aux_lo, m_lo);
      chk("R8", "bpv_aux_hi", bpv_aux_hi, m_hi);
   endtask

   initial begin
      int seed;
      bit start_main;
      seed = $urandom(32'd7781);
      #2;
      chk("R1", "main in reset", bpv_main, 0);
      chk("R1", "aux_hi in reset", bpv_aux_hi, 0);
      chk("R1", "aux_lo in reset", bpv_aux_lo, 0);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      cyc(0, 0);
      chk("R1", "main after reset", bpv_main, 0);
      chk("R1", "aux_lo after reset", bpv_aux_lo, 0);

      // Fast burst: 256 violations, no ticks -> held (R3)
      for (int i = 0; i < MAIN_N; i++) cyc(1, 0);
      chk("R3", "main held before window", bpv_main, 0);
      chk("R7", "aux_lo after 256", bpv_aux_lo, 0);
      // extra violations while held: discarded (R5)
      for (int i = 0; i < 20; i++) cyc(1, 0);
      // 95 ticks: still held
      for (int i = 0; i < HOLD_N - 1; i++) begin cyc(0, 1); cyc(0, 0); end
      chk("R3", "main held at 95 ticks", bpv_main, 0);
      // 96th tick with a held violation on the same edge (R4, R5)
      cyc(1, 1);
      chk("R4", "main released on 96th tick", bpv_main, 1);
      // R5/R6: 255 more violations do not fire even with a long-closed window
      for (int i = 0; i < HOLD_N + 10; i++) cyc(0, 1);
      for (int i = 0; i < MAIN_N - 1; i++) cyc(1, 0);
      chk("R5", "held violations were discarded", bpv_main, 1);
      cyc(1, 0);
      chk("R2", "main on 256th with window closed", bpv_main, 0);

      // Same edge: 256th violation and 96th tick (R2, R4); tick on toggle edge (R6)
      for (int i = 0; i < MAIN_N - 1; i++) cyc(1, 0);
      for (int i = 0; i < HOLD_N - 1; i++) cyc(0, 1);
      chk("R3", "main held at 95 ticks and 255 viol", bpv_main, 0);
      cyc(1, 1);
      chk("R2", "main on coincident viol and tick", bpv_main, 1);
      // R6: tick on toggle edge discarded -> needs 96 more
      for (int i = 0; i < MAIN_N; i++) cyc(1, 0);
      cyc(0, 1);
      for (int i = 0; i < HOLD_N - 2; i++) cyc(0, 1);
      chk("R6", "window restarted after toggle", bpv_main, 1);
      cyc(0, 1);
      chk("R6", "release on 96th fresh tick", bpv_main, 0);

      // R9: idle keeps aux bits
      start_main = bpv_aux_lo;
      for (int i = 0; i < 30; i++) cyc(0, (i % 3) == 0);
      chk("R9", "aux_lo stable without violations", bpv_aux_lo, start_main);

      // Random traffic
      for (int i = 0; i < 40000; i++) begin
         int p = (i < 20000) ? 60 : 8;
         cyc($urandom_range(99, 0) < p, $urandom_range(7, 0) == 0);
      end

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule